// File: doc/BRIEF.md
# OSD Character RAM Auto-Increment Write Port

This block sits between a processor's register-write bus and the write side of an on-screen-display character memory. The memory is organised as rows and columns of 9-bit cells, split into a character-code plane and an attribute plane. Software loads a row index together with a plane-select mode, and separately a column index. It then streams bytes through one of two data ports. The port that is written supplies the ninth bit of the stored word, so a single byte write is enough to store any 9-bit value.

After every data write the column index advances by one. When the column index leaves the last column of a row it returns to column 0 and the row index advances. The row index wraps from the last row back to row 0. This lets software fill whole screens with back-to-back data writes and no further address traffic. Each accepted data write produces one registered, single-cycle write strobe. The strobe carries the plane, row, column and 9-bit word. The read side, the font store and pixel generation belong to other blocks.

Top module: `osd_ram_wport`

## Requirements
- R1: A synchronous reset clears the row index, the column index and the mode to zero and holds `ram_we` low. The first data write after reset goes to row 0, column 0 in the code plane.
- R2: A bus write with `reg_sel` = 0 loads the row index from `reg_wdata[3:0]` and the mode from `reg_wdata[7:6]`. Bits 5:4 are ignored.
- R3: A bus write with `reg_sel` = 1 loads the column index from `reg_wdata[4:0]`. Bits 7:5 are ignored.
- R4: A bus write with `reg_sel` = 2 (data port 0) stores the word {1'b0, `reg_wdata`}.
- R5: A bus write with `reg_sel` = 3 (data port 1) stores the word {1'b1, `reg_wdata`}.
- R6: Each accepted data write gives `ram_we` high for exactly one cycle, in the cycle after the write is sampled. `ram_row`, `ram_col`, `ram_wdata` and `ram_plane` are valid in that same cycle.
- R7: After a data write at a column below 29, the column index increases by one and the row index is unchanged.
- R8: After a data write at column 29, the column index becomes 0 and the row index increases by one.
- R9: After a data write at row 15, column 29, the address becomes row 0, column 0.
- R10: Mode 00 selects the code plane (`ram_plane` = 0). Mode 01 selects the attribute plane (`ram_plane` = 1).
- R11: With mode 10 or 11, a data write produces no strobe, but the address still advances as in R7 to R9.
- R12: A row or column load is used by a data write in the very next cycle.
- R13: A column index loaded at 30 or 31 is used as is by the next data write. That write then wraps the column index to 0 and increments the row index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Bus write enable |
| reg_sel | input | 2 | Register select: 0 row/mode, 1 column, 2 data port 0, 3 data port 1 |
| reg_wdata | input | 8 | Bus write data |
| ram_we | output | 1 | Single-cycle RAM write strobe |
| ram_plane | output | 1 | 0 = code plane, 1 = attribute plane |
| ram_row | output | 4 | RAM row address |
| ram_col | output | 5 | RAM column address |
| ram_wdata | output | 9 | RAM write word |

## Verification
An address load takes effect at the clock edge that samples it. A data write sampled at edge t raises the strobe and its payload from edge t until edge t+1. The bench therefore drives inputs on falling edges and samples the strobe on the next falling edge. At that point it pops the oldest expected write from its queue. An unexpected strobe, or an expected write that is still queued a few cycles after traffic stops, is a failure. This also catches strobes that last too long and writes that should have been suppressed.

// File: rtl/osd_wport_pkg.sv
`timescale 1ns/1ps
package osd_wport_pkg;
   typedef enum logic [1:0] {
      SEL_ROWMODE = 2'd0,
      SEL_COL     = 2'd1,
      SEL_DATA0   = 2'd2,
      SEL_DATA1   = 2'd3
   } reg_sel_e;

   localparam logic [1:0] MODE_CODE = 2'b00;
   localparam logic [1:0] MODE_ATTR = 2'b01;
endpackage

// File: rtl/osd_reg_decode.sv
`timescale 1ns/1ps
module osd_reg_decode
   import osd_wport_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ROW_W  = 4,
   parameter int COL_W  = 5,
   localparam int WORD_W = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              ld_row,
   output logic              ld_col,
   output logic [ROW_W-1:0]  row_val,
   output logic [COL_W-1:0]  col_val,
   output logic              step,
   output logic              fire,
   output logic              plane,
   output logic [WORD_W-1:0] word,
   output logic [1:0]        mode_q
);
   generate
      if (DATA_W < ROW_W + 2) begin : g_bad_row
         $error("DATA_W too narrow for row index plus mode field");
      end
      if (DATA_W < COL_W) begin : g_bad_col
         $error("DATA_W too narrow for column index");
      end
   endgenerate

   logic mode_ok;

   always_comb begin
      ld_row  = reg_wr && (reg_sel == SEL_ROWMODE);
      ld_col  = reg_wr && (reg_sel == SEL_COL);
      step    = reg_wr && (reg_sel == SEL_DATA0 || reg_sel == SEL_DATA1);
      row_val = reg_wdata[ROW_W-1:0];
      col_val = reg_wdata[COL_W-1:0];
      word    = {(reg_sel == SEL_DATA1), reg_wdata};
      mode_ok = (mode_q == MODE_CODE) || (mode_q == MODE_ATTR);
      fire    = step && mode_ok;
      plane   = (mode_q == MODE_ATTR);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_CODE;
      end else if (ld_row) begin
         mode_q <= reg_wdata[DATA_W-1 -: 2];
      end
   end

   AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
      ld_row |=> mode_q == $past(reg_wdata[DATA_W-1 -: 2])) else $error("mode load");  // R2
endmodule

// File: rtl/osd_addr_ctr.sv
`timescale 1ns/1ps
module osd_addr_ctr #(
   parameter int ROW_W    = 4,
   parameter int COL_W    = 5,
   parameter int NUM_ROWS = 16,
   parameter int NUM_COLS = 30
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ld_row,
   input  logic [ROW_W-1:0] row_in,
   input  logic             ld_col,
   input  logic [COL_W-1:0] col_in,
   input  logic             step,
   output logic [ROW_W-1:0] row_q,
   output logic [COL_W-1:0] col_q
);
   localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);
   localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(NUM_ROWS - 1);

   generate
      if (NUM_COLS < 1 || NUM_COLS > (1 << COL_W)) begin : g_bad_cols
         $error("NUM_COLS does not fit COL_W");
      end
      if (NUM_ROWS < 1 || NUM_ROWS > (1 << ROW_W)) begin : g_bad_rows
         $error("NUM_ROWS does not fit ROW_W");
      end
   endgenerate

   logic col_last, row_last;

   generate
      if (NUM_COLS == (1 << COL_W)) begin : g_col_full
         assign col_last = &col_q;
      end else begin : g_col_cmp
         assign col_last = (col_q >= LAST_COL);
      end
      if (NUM_ROWS == (1 << ROW_W)) begin : g_row_full
         assign row_last = &row_q;
      end else begin : g_row_cmp
         assign row_last = (row_q >= LAST_ROW);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         row_q <= '0;
         col_q <= '0;
      end else begin
         if (ld_row) row_q <= row_in;
         if (ld_col) col_q <= col_in;
         if (step) begin
            if (col_last) begin
               col_q <= '0;
               row_q <= row_last ? '0 : row_q + ROW_W'(1);
            end else begin
               col_q <= col_q + COL_W'(1);
            end
         end
      end
   end

   AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (step && col_q < LAST_COL) |=> (col_q == $past(col_q) + COL_W'(1)) && (row_q == $past(row_q)))
      else $error("column advance");  // R7
   AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
      (step && col_q >= LAST_COL) |=> col_q == '0) else $error("column wrap");  // R8
   AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
      (step && col_q >= LAST_COL && row_q >= LAST_ROW) |=> row_q == '0) else $error("row wrap");  // R9
   AST_COL_LOAD: assert property (@(posedge clk) disable iff (rst)
      (ld_col && !step) |=> col_q == $past(col_in)) else $error("column load");  // R12
endmodule

// File: rtl/osd_wr_stage.sv
`timescale 1ns/1ps
module osd_wr_stage #(
   parameter int ROW_W  = 4,
   parameter int COL_W  = 5,
   parameter int WORD_W = 9
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fire,
   input  logic              plane_in,
   input  logic [ROW_W-1:0]  row_in,
   input  logic [COL_W-1:0]  col_in,
   input  logic [WORD_W-1:0] word_in,
   output logic              we_q,
   output logic              plane_q,
   output logic [ROW_W-1:0]  row_q,
   output logic [COL_W-1:0]  col_q,
   output logic [WORD_W-1:0] word_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         we_q <= 1'b0;
      end else begin
         we_q <= fire;
      end
   end

   always_ff @(posedge clk) begin
      if (fire) begin
         plane_q <= plane_in;
         row_q   <= row_in;
         col_q   <= col_in;
         word_q  <= word_in;
      end
   end

   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      we_q |-> $past(fire)) else $error("strobe without write");  // R6
   AST_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
      fire |=> we_q && word_q == $past(word_in) && col_q == $past(col_in)) else $error("payload");  // R6
endmodule

// File: rtl/osd_ram_wport.sv
`timescale 1ns/1ps
module osd_ram_wport
   import osd_wport_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ROW_W    = 4,
   parameter int COL_W    = 5,
   parameter int NUM_ROWS = 16,
   parameter int NUM_COLS = 30,
   localparam int WORD_W  = DATA_W + 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic              ram_we,
   output logic              ram_plane,
   output logic [ROW_W-1:0]  ram_row,
   output logic [COL_W-1:0]  ram_col,
   output logic [WORD_W-1:0] ram_wdata
);
   logic              ld_row, ld_col, step, fire, plane;
   logic [ROW_W-1:0]  row_val, row_cur;
   logic [COL_W-1:0]  col_val, col_cur;
   logic [WORD_W-1:0] word;
   logic [1:0]        mode_q;

   osd_reg_decode #(.DATA_W(DATA_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ld_row(ld_row), .ld_col(ld_col), .row_val(row_val), .col_val(col_val),
      .step(step), .fire(fire), .plane(plane), .word(word), .mode_q(mode_q)
   );

   osd_addr_ctr #(.ROW_W(ROW_W), .COL_W(COL_W), .NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS)) u_ctr (
      .clk(clk), .rst(rst), .ld_row(ld_row), .row_in(row_val), .ld_col(ld_col),
      .col_in(col_val), .step(step), .row_q(row_cur), .col_q(col_cur)
   );

   osd_wr_stage #(.ROW_W(ROW_W), .COL_W(COL_W), .WORD_W(WORD_W)) u_out (
      .clk(clk), .rst(rst), .fire(fire), .plane_in(plane), .row_in(row_cur),
      .col_in(col_cur), .word_in(word), .we_q(ram_we), .plane_q(ram_plane),
      .row_q(ram_row), .col_q(ram_col), .word_q(ram_wdata)
   );

   AST_NINTH_BIT: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_sel == SEL_DATA1 && fire) |=> ram_wdata[WORD_W-1]) else $error("port 1 msb");  // R5
   AST_NINTH_CLR: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && reg_sel == SEL_DATA0 && fire) |=> !ram_wdata[WORD_W-1]) else $error("port 0 msb");  // R4
   AST_RSV_SILENT: assert property (@(posedge clk) disable iff (rst)
      (reg_wr && mode_q[1]) |=> !ram_we) else $error("reserved mode wrote");  // R11
   AST_ATTR_PLANE: assert property (@(posedge clk) disable iff (rst)
      (step && mode_q == MODE_ATTR) |=> ram_we && ram_plane) else $error("plane");  // R10
endmodule

// File: tb/osd_ram_wport_tb.sv
`timescale 1ns/1ps
module osd_ram_wport_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       reg_wr = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic [7:0] reg_wdata = 8'd0;
   logic       ram_we, ram_plane;
   logic [3:0] ram_row;
   logic [4:0] ram_col;
   logic [8:0] ram_wdata;

   always #4 clk = ~clk;

   osd_ram_wport dut_i (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .ram_we(ram_we), .ram_plane(ram_plane), .ram_row(ram_row), .ram_col(ram_col),
      .ram_wdata(ram_wdata)
   );

   typedef struct {
      bit       plane;
      bit [3:0] row;
      bit [4:0] col;
      bit [8:0] word;
      string    tag;
   } exp_t;

   exp_t q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit [3:0] row_m = 0;
   bit [4:0] col_m = 0;
   bit [1:0] mode_m = 0;

   task automatic bus(input bit [1:0] sel, input bit [7:0] val);
      reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic set_row(input bit [7:0] val);
      mode_m = val[7:6]; row_m = val[3:0];
      bus(2'd0, val);
   endtask

   task automatic set_col(input bit [7:0] val);
      col_m = val[4:0];
      bus(2'd1, val);
   endtask

   task automatic put(input bit port, input bit [7:0] val, input string tag);
      exp_t e;
      if (mode_m < 2) begin
         e.plane = mode_m[0]; e.row = row_m; e.col = col_m;
         e.word = {port, val}; e.tag = tag;
         q.push_back(e);
      end
      if (col_m >= 5'd29) begin
         col_m = 0;
         row_m = (row_m == 4'd15) ? 4'd0 : row_m + 4'd1;
      end else begin
         col_m = col_m + 5'd1;
      end
      bus(port ? 2'd3 : 2'd2, val);
   endtask

   task automatic drain(input string tag);
      repeat (3) @(negedge clk);
      checks++;
      if (q.size() != 0) begin
         fails++;
         $display("FAIL %s: %0d expected writes missing (expected 0)", tag, q.size());
         q.delete();
      end
   endtask

   always @(negedge clk) begin
      if (!rst && ram_we && !done) begin
         checks++;
         if (q.size() == 0) begin
            fails++;
            $display("FAIL R6: unexpected strobe row=%0d col=%0d word=%h (expected none)",
                     ram_row, ram_col, ram_wdata);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (ram_plane !== e.plane || ram_row !== e.row || ram_col !== e.col ||
                ram_wdata !== e.word) begin
               fails++;
               $display("FAIL %s: got p=%0d r=%0d c=%0d w=%h expected p=%0d r=%0d c=%0d w=%h",
                        e.tag, ram_plane, ram_row, ram_col, ram_wdata,
                        e.plane, e.row, e.col, e.word);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; fails++;
         $display("FAIL watchdog: run hung (expected completion)");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (ram_we !== 1'b0) begin
         fails++; $display("FAIL R1: ram_we=%b in reset (expected 0)", ram_we);
      end
      rst = 1'b0;
      @(negedge clk);
      checks++;
      if (ram_we !== 1'b0) begin
         fails++; $display("FAIL R1: ram_we=%b after reset (expected 0)", ram_we);
      end
      // R1 R4: first write lands at row 0 col 0 code plane
      put(0, 8'hA5, "R1");
      put(1, 8'h3C, "R5");
      put(0, 8'hFF, "R4");
      for (int i = 0; i < 5; i++) put(i[0], 8'(i * 17), "R7");
      drain("R6");
      // R8: column wrap into next row
      set_row(8'h02); set_col(8'h1C);
      put(0, 8'h11, "R8"); put(1, 8'h22, "R8"); put(0, 8'h33, "R8");
      drain("R8");
      // R9: full wrap from last cell
      set_row(8'h0F); set_col(8'h1D);
      put(1, 8'h44, "R9"); put(0, 8'h55, "R9");
      drain("R9");
      // R2 R10: attribute mode, ignored bits 5:4 set
      set_row(8'h76); set_col(8'h03);
      put(1, 8'h66, "R10"); put(0, 8'h77, "R2");
      set_row(8'h05);
      put(0, 8'h88, "R10");
      drain("R10");
      // R3: upper column bits ignored
      set_col(8'hE7);
      put(0, 8'h99, "R3");
      drain("R3");
      // R11: reserved modes suppress strobe, address still moves
      set_row(8'h84); set_col(8'h1C);
      put(0, 8'h01, "R11"); put(1, 8'h02, "R11");
      set_row(8'hC4);
      put(0, 8'h03, "R11");
      drain("R11");
      set_row(8'h05);
      put(0, 8'h04, "R11");
      drain("R11");
      // R12: back-to-back load then data, alternating
      for (int k = 0; k < 4; k++) begin
         set_col(8'(k * 7));
         put(k[0], 8'(8'hB0 + k), "R12");
      end
      drain("R12");
      // R13: out-of-range column used then wrapped
      set_row(8'h09); set_col(8'h1F);
      put(0, 8'hC1, "R13"); put(0, 8'hC2, "R13");
      set_col(8'h1E);
      put(1, 8'hC3, "R13"); put(1, 8'hC4, "R13");
      drain("R13");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule